// File: doc/BRIEF.md
# Memory Protection Violation Capture Unit

This unit sits beside the descriptor-matching logic of a memory protection scheme for one CPU. Each cycle it receives one bus access with its address, kind (read, write or instruction fetch) and privilege level. It also receives the match results: whether any descriptor covers the address, and whether that region is read-only or no-execute. From these it decides whether the access must be blocked. It pulses a non-maskable interrupt one cycle after every violation.

On the first violation it latches a pending error flag. In the same cycle it captures a snapshot: the cause bits, the privilege level of the access and the faulting address. This snapshot stays frozen until software clears the flag with a write-one-to-clear. Software reads the snapshot through a small byte-wide register port.

A supervisor may need to reach the unit's own registers while a fault is pending. To allow this, supervisor accesses to a configurable four-byte window are exempt from blocking while the flag is set. The flag can therefore always be cleared.

Top module: `mpv_capture_top`

## Requirements
- R1: After reset, all four registers read 0x00, `nmi_pulse` is 0, and `acc_block` is 0 while `acc_valid` is 0.
- R2: `acc_block` is 1 in the same cycle as a valid access that is a violation, and 0 for any other valid access. An access is a violation when any of these holds: the address is not covered by a descriptor (`acc_hit`=0), it writes a read-only region, or it fetches from a no-execute region. Reads of read-only regions, writes to no-execute regions and fetches from read-only regions are allowed.
- R3: Register offset 0 holds the flags. Bit 7 is the pending error flag, bit 6 the write-protect cause, bit 5 the no-execute cause and bit 0 the supervisor flag. Bits 4 to 1 read 0. A violation with the flag clear sets bit 7 at the next clock edge.
- R4: On capture, bit 6 = 1 when a write hit a read-only region and bit 5 = 1 when a fetch hit a no-execute region. Both bits are 0 for an uncovered address.
- R5: On capture, bit 0 of offset 0 equals the access's `acc_super` value.
- R6: On capture, the faulting address is readable as bytes. Offset 1 gives address bits 22:16 in bits 6:0, with bit 7 reading 0. Offset 2 gives bits 15:8 and offset 3 gives bits 7:0.
- R7: While the flag is set and no clearing write occurs, later violations change neither the cause bits, the supervisor bit nor the address.
- R8: A write to offset 0 with data bit 7 = 1 clears the pending flag, and the cause and supervisor bits keep their values. Writes with bit 7 = 0, and writes to offsets 1 to 3, change nothing.
- R9: `nmi_pulse` is 1 for exactly the one cycle after each violating access, whether or not the flag was already set.
- R10: A pending flag does not weaken blocking: violations outside the exemption in R11 are still blocked.
- R11: While the flag is set, a supervisor access whose address lies in [`REG_BASE`, `REG_BASE`+4) is not a violation. It is not blocked, raises no interrupt and is not captured. With the flag clear, or for a user access, the normal rules apply.
- R12: When a clearing write and a violation fall in the same cycle, the violation wins. The flag stays set and the new cause, supervisor bit and address are captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 23 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access made in supervisor state |
| acc_hit | input | 1 | Some descriptor covers the address |
| acc_ro | input | 1 | Matched region is read-only |
| acc_nx | input | 1 | Matched region is no-execute |
| cfg_wr | input | 1 | Register write strobe |
| cfg_off | input | 2 | Register offset (0 flags, 1..3 address bytes) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| acc_block | output | 1 | Access is blocked (combinational) |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |

## Verification
`acc_block` and `cfg_rdata` are combinational. The bench drives an access just after a rising edge and samples `acc_block` in that same cycle. It moves `cfg_off` and samples the read data a moment later. The captured flags, the captured address and `nmi_pulse` are each due one edge after the violating cycle, so they are checked just after that edge. `nmi_pulse` is checked once more one edge later to confirm it lasted only one cycle. Clears and the same-cycle clear-versus-violation case are driven in the same slot as an access, and their result is read after the following edge.

// File: rtl/mpv_pkg.sv
package mpv_pkg;
  // bit positions of the flag register at offset 0
  localparam int FLG_AEF = 7;
  localparam int FLG_WPF = 6;
  localparam int FLG_NXF = 5;
  localparam int FLG_SVS = 0;

  typedef struct packed {
    logic wpf;
    logic nxf;
    logic svs;
  } cause_t;
endpackage

// File: rtl/mpv_access_check.sv
module mpv_access_check
  import mpv_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter logic [ADDR_W-1:0] REG_BASE = 'h40,
  parameter int REG_SPAN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic              acc_super,
  input  logic              acc_hit,
  input  logic              acc_ro,
  input  logic              acc_nx,
  input  logic              aef,
  output logic              viol,
  output cause_t            cause,
  output logic              block
);
  localparam logic [ADDR_W:0] RANGE_LO = {1'b0, REG_BASE};
  localparam logic [ADDR_W:0] RANGE_HI = RANGE_LO + (ADDR_W+1)'(REG_SPAN);

  logic in_regs, ovr, wp_hit, nx_hit, raw;

  always_comb begin
    in_regs = ({1'b0, acc_addr} >= RANGE_LO) && ({1'b0, acc_addr} < RANGE_HI);
    ovr     = acc_valid && aef && acc_super && in_regs;
    wp_hit  = acc_hit && acc_write && acc_ro;
    nx_hit  = acc_hit && acc_fetch && acc_nx;
    raw     = acc_valid && (!acc_hit || wp_hit || nx_hit);
    viol    = raw && !ovr;
    block   = viol;
    cause.wpf = wp_hit;
    cause.nxf = nx_hit;
    cause.svs = acc_super;
  end

  // R10: an uncovered access outside the register window is always blocked
  assert_block_uncovered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && !in_regs) |-> block);
  // R11: exempt supervisor register access while pending is never blocked
  assert_reg_override_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && aef && acc_super && in_regs) |-> !block);
endmodule

// File: rtl/mpv_status_regs.sv
module mpv_status_regs
  import mpv_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              viol,
  input  cause_t            cause_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              clr,
  output logic              aef_q,
  output cause_t            cause_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              nmi_q
);
  logic aef_d, cap_en;

  always_comb begin
    cap_en = viol && (!aef_q || clr);
    aef_d  = viol || (aef_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aef_q   <= 1'b0;
      nmi_q   <= 1'b0;
      cause_q <= '0;
      addr_q  <= '0;
    end else begin
      aef_q <= aef_d;
      nmi_q <= viol;
      if (cap_en) begin
        cause_q <= cause_in;
        addr_q  <= addr_in;
      end
    end
  end

  assert_set_on_viol_R3: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> aef_q);
  assert_nmi_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> nmi_q);
  assert_hold_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (aef_q && !clr) |=> ($stable(addr_q) && $stable(cause_q)));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !viol) |=> !aef_q);
  assert_clash_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && viol) |=> (aef_q && addr_q == $past(addr_in)));
endmodule

// File: rtl/mpv_reg_if.sv
module mpv_reg_if
  import mpv_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int NUM_AB = (ADDR_W + 7) / 8,
  parameter int OFF_W  = $clog2(NUM_AB + 1)
) (
  input  logic              cfg_wr,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [7:0]        cfg_wdata,
  input  logic              aef,
  input  cause_t            cause,
  input  logic [ADDR_W-1:0] addr,
  output logic              clr,
  output logic [7:0]        rdata
);
  localparam int PAD_W = NUM_AB * 8;

  logic [PAD_W-1:0] pad;
  logic             unused_wbits;

  assign pad          = PAD_W'(addr);
  assign unused_wbits = ^cfg_wdata[6:0];
  assign clr          = cfg_wr && (cfg_off == '0) && cfg_wdata[FLG_AEF];

  always_comb begin
    rdata = '0;
    if (cfg_off == '0) begin
      rdata[FLG_AEF] = aef;
      rdata[FLG_WPF] = cause.wpf;
      rdata[FLG_NXF] = cause.nxf;
      rdata[FLG_SVS] = cause.svs;
    end else begin
      for (int k = 1; k <= NUM_AB; k++) begin
        if (cfg_off == OFF_W'(k)) rdata = pad[(NUM_AB-k)*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/mpv_capture_top.sv
module mpv_capture_top
  import mpv_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter logic [ADDR_W-1:0] REG_BASE = 'h40,
  localparam int NUM_AB = (ADDR_W + 7) / 8,
  localparam int OFF_W  = $clog2(NUM_AB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic              acc_super,
  input  logic              acc_hit,
  input  logic              acc_ro,
  input  logic              acc_nx,
  input  logic              cfg_wr,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              acc_block,
  output logic              nmi_pulse
);
  localparam int REG_SPAN = NUM_AB + 1;

  logic              viol, aef_q, clr;
  cause_t            cause_c, cause_q;
  logic [ADDR_W-1:0] addr_q;

  mpv_access_check #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .REG_SPAN(REG_SPAN)) u_check (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_super(acc_super),
    .acc_hit(acc_hit), .acc_ro(acc_ro), .acc_nx(acc_nx), .aef(aef_q),
    .viol(viol), .cause(cause_c), .block(acc_block)
  );

  mpv_status_regs #(.ADDR_W(ADDR_W)) u_status (
    .clk(clk), .rst_n(rst_n), .viol(viol), .cause_in(cause_c), .addr_in(acc_addr),
    .clr(clr), .aef_q(aef_q), .cause_q(cause_q), .addr_q(addr_q), .nmi_q(nmi_pulse)
  );

  mpv_reg_if #(.ADDR_W(ADDR_W), .NUM_AB(NUM_AB), .OFF_W(OFF_W)) u_regs (
    .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .aef(aef_q),
    .cause(cause_q), .addr(addr_q), .clr(clr), .rdata(cfg_rdata)
  );

  // R9: the interrupt is a single-cycle pulse unless violations are back to back
  assert_nmi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pulse && !acc_block) |=> !nmi_pulse);
endmodule

// File: tb/test_mpv_capture_top.sv
module test_mpv_capture_top;
  localparam logic [22:0] BASE = 23'h40;

  logic        clk, rst_n;
  logic        acc_valid, acc_write, acc_fetch, acc_super, acc_hit, acc_ro, acc_nx;
  logic [22:0] acc_addr;
  logic        cfg_wr;
  logic [1:0]  cfg_off;
  logic [7:0]  cfg_wdata, cfg_rdata;
  logic        acc_block, nmi_pulse;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  mpv_capture_top i_mpv_capture_top (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_super(acc_super),
    .acc_hit(acc_hit), .acc_ro(acc_ro), .acc_nx(acc_nx), .cfg_wr(cfg_wr),
    .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_block(acc_block), .nmi_pulse(nmi_pulse)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // vector: write fetch super hit ro nx | exp_block exp_wpf exp_nxf | addr
  typedef struct packed {
    logic w, f, s, h, ro, nx;
    logic blk, wpf, nxf;
    logic [22:0] addr;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0, 23'h012345},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b0, 23'h7ABCDE},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b1, 23'h0055AA},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 23'h400001},
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0, 23'h000001},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0, 23'h000002},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0, 23'h000003},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0, 23'h7FFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance to just after the next rising edge
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic rd(input logic [1:0] off, output logic [7:0] d);
    cfg_off = off;
    #1;
    d = cfg_rdata;
  endtask

  task automatic idle();
    acc_valid = 0; acc_write = 0; acc_fetch = 0; acc_super = 0;
    acc_hit = 1; acc_ro = 0; acc_nx = 0; acc_addr = '0;
    cfg_wr = 0; cfg_wdata = '0;
  endtask

  task automatic access(input logic w, f, s, h, ro, nx, input logic [22:0] a);
    acc_valid = 1; acc_write = w; acc_fetch = f; acc_super = s;
    acc_hit = h; acc_ro = ro; acc_nx = nx; acc_addr = a;
    #1;
  endtask

  task automatic wr(input logic [1:0] off, input logic [7:0] d);
    cfg_wr = 1; cfg_off = off; cfg_wdata = d;
  endtask

  task automatic chk_addr(input string req, input logic [22:0] a);
    logic [7:0] d;
    rd(2'd1, d); chk(req, d, {1'b0, a[22:16]});
    rd(2'd2, d); chk(req, d, a[15:8]);
    rd(2'd3, d); chk(req, d, a[7:0]);
  endtask

  initial begin
    #1500000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle();
    cfg_off = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();

    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      rd(2'(k), d);
      chk("R1 reg after reset", d, 8'h00);
    end
    chk("R1 nmi after reset", nmi_pulse, 0);
    chk("R1 block idle", acc_block, 0);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 8'h80);
      tick();
      idle();
      access(VEC[i].w, VEC[i].f, VEC[i].s, VEC[i].h, VEC[i].ro, VEC[i].nx, VEC[i].addr);
      chk("R2 block", acc_block, VEC[i].blk);
      tick();
      idle();
      chk("R9 nmi after access", nmi_pulse, VEC[i].blk);
      rd(2'd0, d);
      if (VEC[i].blk) begin
        chk("R3 R4 R5 flags", d, {1'b1, VEC[i].wpf, VEC[i].nxf, 4'b0, VEC[i].s});
        chk_addr("R6 address", VEC[i].addr);
      end else begin
        chk("R3 no flag", d[7], 0);
      end
      tick();
      chk("R9 single pulse", nmi_pulse, 0);
    end

    // R7 R9 R10: second violation while pending
    wr(2'd0, 8'h80); tick(); idle();
    access(1, 0, 0, 1, 1, 0, 23'h123456);
    tick(); idle();
    access(0, 1, 1, 1, 0, 1, 23'h654321);
    chk("R10 still blocked", acc_block, 1);
    tick(); idle();
    chk("R9 nmi while pending", nmi_pulse, 1);
    rd(2'd0, d);
    chk("R7 flags held", d, 8'hC0);
    chk_addr("R7 address held", 23'h123456);

    // R8: ignored writes
    wr(2'd0, 8'h7F); tick(); idle();
    rd(2'd0, d);
    chk("R8 write zero ignored", d, 8'hC0);
    wr(2'd1, 8'hFF); tick(); idle();
    wr(2'd3, 8'h80); tick(); idle();
    chk_addr("R8 address write ignored", 23'h123456);
    rd(2'd0, d);
    chk("R8 other offset no clear", d, 8'hC0);

    // R11: override while pending
    access(0, 0, 1, 0, 0, 0, BASE + 23'd2);
    chk("R11 super reg access allowed", acc_block, 0);
    tick(); idle();
    chk("R11 no nmi", nmi_pulse, 0);
    chk_addr("R11 not captured", 23'h123456);
    access(1, 0, 0, 0, 0, 0, BASE + 23'd2);
    chk("R11 user still blocked", acc_block, 1);
    tick(); idle();
    access(0, 0, 1, 0, 0, 0, BASE + 23'd4);
    chk("R11 outside window blocked", acc_block, 1);
    access(0, 0, 1, 0, 0, 0, BASE - 23'd1);
    chk("R11 below window blocked", acc_block, 1);
    idle();

    // R8: clear keeps cause bits
    wr(2'd0, 8'h80); tick(); idle();
    rd(2'd0, d);
    chk("R8 clear flag", d, 8'h40);

    // R11: no override once clear
    access(0, 0, 1, 0, 0, 0, BASE + 23'd2);
    chk("R11 blocked when flag clear", acc_block, 1);
    tick(); idle();
    rd(2'd0, d);
    chk("R11 captured when clear", d, 8'h81);
    chk_addr("R11 captured address", BASE + 23'd2);

    // R12: clear and violation in the same cycle
    wr(2'd0, 8'h80);
    access(0, 1, 0, 1, 0, 1, 23'h2468AC);
    tick(); idle();
    rd(2'd0, d);
    chk("R12 violation wins", d, 8'hA0);
    chk_addr("R12 new address", 23'h2468AC);

    // R1: reset again mid-run
    rst_n = 0;
    #1;
    rd(2'd0, d);
    chk("R1 async reset clears", d, 8'h00);
    tick();
    rst_n = 1;
    tick();
    chk_addr("R1 address reset", 23'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule